// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Idle Master

This block decides which of three real bus masters, or a built-in idle master, owns a shared AHB address bus. Each master presents a request and a lock line. The arbiter also watches the global ready signal, the slave response, and the transfer type of the current owner. From these it produces a one-hot grant vector, a registered address-phase owner index that steers the address and control multiplexer, and a data-phase owner index that steers the write-data and response paths.

The order is fixed: master 3 first, then the idle master (index 0), then master 2, then master 1. Master 1 is the fallback owner. The idle master drives only IDLE transfers. Its request line works as a pause, so a low-priority master cannot take the bus while it is high. The idle master also takes the bus when no real master can legally use it.

A master that receives a SPLIT response is removed from arbitration. It stays out until its bit of the split-release input is pulsed. The request and lock inputs of the idle master should be tied low when they are not used.

Top module: `ahb_prio_arbiter`

## Requirements
- R1: After a synchronous reset, both owner indices are 1 and every split mask bit is clear. With no requests, master 1 is granted.
- R2: Among eligible requesters the grant follows the fixed order 3, 0, 2, 1. Master 1 is eligible whenever it is not masked, even without a request.
- R3: Exactly one bit of `grant_o` is high in every cycle.
- R4: `addr_owner_o` takes the granted index on a clock edge where `hready_i` is high. It holds its value across edges where `hready_i` is low, while `grant_o` may still change.
- R5: `data_owner_o` takes the previous `addr_owner_o` value on each edge where `hready_i` is high.
- R6: While `bus_req_i[0]` is high and no lock is held, masters 2 and 1 are not granted. Master 3 still wins.
- R7: While the lock bit of the address-phase owner is high, that owner keeps the grant against any request. This holds until the final cycle of a SPLIT or RETRY response.
- R8: A SPLIT completes when `hready_i`=1 and `hresp_i`=2'b11 (OKAY=00, ERROR=01, RETRY=10, SPLIT=11). It masks the data-phase owner from that cycle onward. The mask bit clears on the edge after its `split_clr_i` bit is pulsed. If a set and a release hit the same bit in one cycle, the set wins.
- R9: If the transfer in its data phase was locked and not IDLE (`htrans_i`=2'b00 means IDLE) and it completes with SPLIT, the idle master is granted.
- R10: If master 1 is masked and no other eligible real master requests, the idle master is granted. This includes the case where every real master is masked.
- R11: The final cycle of a RETRY response ends a lock hold, and arbitration uses the normal order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_i | input | 4 | Request per master; bit 0 is the idle master (pause) |
| bus_lock_i | input | 4 | Lock per master; bit 0 is the idle master |
| hready_i | input | 1 | Global transfer-done signal |
| hresp_i | input | 2 | Current slave response |
| htrans_i | input | 2 | Transfer type driven by the address-phase owner |
| split_clr_i | input | 4 | One-cycle release pulse per master for its split mask |
| grant_o | output | 4 | One-hot grant |
| addr_owner_o | output | 2 | Registered address-phase owner index |
| data_owner_o | output | 2 | Registered data-phase owner index |

## Verification
The critical overlap is a SPLIT completing on one master in the same cycle that a release pulse arrives for another master. The grant in that cycle must treat both as still masked. On the next cycle only the released one returns. The bench builds this by splitting master 1 first. It then ends a SPLIT on master 2 while pulsing the release of master 1. It checks that the idle master is granted in that cycle and that master 1, not master 2, wins the cycle after. The bench also drives a lock hold alongside a higher request and a RETRY end in one cycle, and checks that the RETRY breaks the hold.

// File: rtl/arb_pkg.sv
// Shared constants, types and the fixed priority table for the arbiter.
// Assumes exactly four master slots: index 0 is the internal idle master.
package arb_pkg;
    localparam int unsigned NUM_MST  = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_MST);
    localparam int unsigned IDLE_MST = 0;
    localparam int unsigned DFLT_MST = 1;

    typedef logic [IDX_W-1:0]   mst_idx_t;
    typedef logic [NUM_MST-1:0] mst_vec_t;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } resp_e;

    localparam logic [1:0] TR_IDLE = 2'b00;

    // Maps a priority rank (0 = highest) to the master index holding it.
    function automatic mst_idx_t rank_to_idx(input int unsigned rank);
        case (rank)
            0:       return mst_idx_t'(3);
            1:       return mst_idx_t'(IDLE_MST);
            2:       return mst_idx_t'(2);
            default: return mst_idx_t'(DFLT_MST);
        endcase
    endfunction
endpackage

// File: rtl/arb_split_track.sv
// Holds one split mask bit per master.
// A bit is set when a SPLIT completes for the data-phase owner.
// A bit is cleared by a release pulse; a set in the same cycle wins.
// Assumes: split_end is high only on the final (ready) cycle of a SPLIT.
module arb_split_track
    import arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     split_end,
    input  mst_idx_t dp_owner,
    input  mst_vec_t split_clr,
    output mst_vec_t mask_q,
    output mst_vec_t mask_eff
);
    mst_vec_t set_vec;

    // Decode which master the completing SPLIT belongs to.
    for (genvar i = 0; i < NUM_MST; i++) begin : g_set
        assign set_vec[i] = split_end && (dp_owner == mst_idx_t'(i));
    end

    // Mask register: release first, then set, so a set overrides a release.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q & ~split_clr) | set_vec;
    end

    // Mask as seen by this cycle's arbitration, including a SPLIT ending now.
    assign mask_eff = mask_q | set_vec;

    for (genvar i = 0; i < NUM_MST; i++) begin : g_chk
        // R8: a completed SPLIT leaves the owner masked on the next cycle.
        p_split_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (split_end && dp_owner == mst_idx_t'(i)) |=> mask_q[i]);
        // R8: a release with no competing set clears the bit.
        p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (split_clr[i] && !(split_end && dp_owner == mst_idx_t'(i))) |=> !mask_q[i]);
    end
endmodule

// File: rtl/arb_pick.sv
// Combinational grant selection.
// Order of decisions:
//   1. locked SPLIT goes to the idle master;
//   2. a lock hold keeps the current owner;
//   3. fixed rank order over eligible masters;
//   4. if no master is eligible, the idle master.
// Assumes: mask_eff already contains any SPLIT that completes this cycle.
module arb_pick
    import arb_pkg::*;
(
    input  mst_vec_t req,
    input  mst_vec_t lock,
    input  mst_idx_t owner,
    input  mst_vec_t mask_eff,
    input  logic     split_end,
    input  logic     retry_end,
    input  logic     dp_lock,
    output mst_idx_t grant_idx,
    output mst_vec_t grant_vec
);
    mst_vec_t elig;

    // Eligibility per slot: idle follows its request, default needs only no mask.
    for (genvar i = 0; i < NUM_MST; i++) begin : g_elig
        if (i == IDLE_MST) begin : g_idle
            assign elig[i] = req[i];
        end else if (i == DFLT_MST) begin : g_dflt
            assign elig[i] = !mask_eff[i];
        end else begin : g_real
            assign elig[i] = req[i] && !mask_eff[i];
        end
    end

    // Winner selection with special cases ahead of the rank scan.
    always_comb begin
        logic found;
        found     = 1'b0;
        grant_idx = mst_idx_t'(IDLE_MST);
        if (split_end && dp_lock) begin
            grant_idx = mst_idx_t'(IDLE_MST);
        end else if (lock[owner] && !mask_eff[owner] && !split_end && !retry_end) begin
            grant_idx = owner;
        end else begin
            for (int r = 0; r < NUM_MST; r++) begin
                if (!found && elig[rank_to_idx(r)]) begin
                    grant_idx = rank_to_idx(r);
                    found     = 1'b1;
                end
            end
        end
    end

    // Expand the winner index into a one-hot vector.
    for (genvar i = 0; i < NUM_MST; i++) begin : g_onehot
        assign grant_vec[i] = (grant_idx == mst_idx_t'(i));
    end
endmodule

// File: rtl/arb_phase_regs.sv
// Address-phase and data-phase owner registers, plus the lock flag
// of the transfer now in its data phase.
// All three advance only on edges where the bus is ready.
// Assumes: htrans is driven by the current address-phase owner.
module arb_phase_regs
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hready,
    input  mst_idx_t   grant_idx,
    input  mst_vec_t   lock,
    input  logic [1:0] htrans,
    output mst_idx_t   owner_q,
    output mst_idx_t   dp_owner_q,
    output logic       dp_lock_q
);
    // Pipeline the ownership one accepted transfer at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q    <= mst_idx_t'(DFLT_MST);
            dp_owner_q <= mst_idx_t'(DFLT_MST);
            dp_lock_q  <= 1'b0;
        end else if (hready) begin
            owner_q    <= grant_idx;
            dp_owner_q <= owner_q;
            dp_lock_q  <= lock[owner_q] && (htrans != TR_IDLE);
        end
    end

    // R4: the owner does not move while the bus is stalled.
    p_owner_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(owner_q));
    // R4: on a ready edge the owner takes the granted index.
    p_owner_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hready |=> owner_q == $past(grant_idx));
    // R5: the data-phase owner trails the address-phase owner by one transfer.
    p_dp_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hready |=> dp_owner_q == $past(owner_q));
endmodule

// File: rtl/ahb_prio_arbiter.sv
// Top of the fixed-priority arbiter: response decode, split tracking,
// grant selection and owner registers.
// Assumes: a SPLIT or RETRY response lasts two cycles, and only its
// second (ready-high) cycle triggers re-arbitration.
module ahb_prio_arbiter
    import arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MST-1:0]   bus_req_i,
    input  logic [NUM_MST-1:0]   bus_lock_i,
    input  logic                 hready_i,
    input  logic [1:0]           hresp_i,
    input  logic [1:0]           htrans_i,
    input  logic [NUM_MST-1:0]   split_clr_i,
    output logic [NUM_MST-1:0]   grant_o,
    output logic [IDX_W-1:0]     addr_owner_o,
    output logic [IDX_W-1:0]     data_owner_o
);
    logic     split_end;
    logic     retry_end;
    logic     dp_lock;
    mst_vec_t mask_q;
    mst_vec_t mask_eff;
    mst_idx_t grant_idx;
    mst_vec_t grant_vec;
    mst_idx_t owner_q;
    mst_idx_t dp_owner_q;

    // Final cycle of a two-cycle SPLIT or RETRY response.
    assign split_end = hready_i && (hresp_i == RSP_SPLIT);
    assign retry_end = hready_i && (hresp_i == RSP_RETRY);

    arb_split_track u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .split_end (split_end),
        .dp_owner  (dp_owner_q),
        .split_clr (split_clr_i),
        .mask_q    (mask_q),
        .mask_eff  (mask_eff)
    );

    arb_pick u_pick (
        .req       (bus_req_i),
        .lock      (bus_lock_i),
        .owner     (owner_q),
        .mask_eff  (mask_eff),
        .split_end (split_end),
        .retry_end (retry_end),
        .dp_lock   (dp_lock),
        .grant_idx (grant_idx),
        .grant_vec (grant_vec)
    );

    arb_phase_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready_i),
        .grant_idx  (grant_idx),
        .lock       (bus_lock_i),
        .htrans     (htrans_i),
        .owner_q    (owner_q),
        .dp_owner_q (dp_owner_q),
        .dp_lock_q  (dp_lock)
    );

    assign grant_o      = grant_vec;
    assign addr_owner_o = owner_q;
    assign data_owner_o = dp_owner_q;

    // R3: exactly one grant line is high.
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1);
    // R6: a pause request keeps masters 2 and 1 off the bus unless a lock holds.
    p_pause_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i[IDLE_MST] && !bus_lock_i[owner_q]) |-> (!grant_o[1] && !grant_o[2]));
    // R9: a locked transfer that is split hands the bus to the idle master.
    p_locked_split_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (split_end && dp_lock) |-> grant_o[IDLE_MST]);
    for (genvar i = 1; i < NUM_MST; i++) begin : g_mask_chk
        // R8: a masked real master is never granted.
        p_masked_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[i] |-> !grant_o[i]);
    end
endmodule

// File: tb/tb_ahb_prio_arbiter.sv
// Scoreboard bench: step() drives one cycle and queues expectations,
// the monitor pops and compares them mid-cycle.
module tb_ahb_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_req_i, bus_lock_i, split_clr_i;
    logic       hready_i;
    logic [1:0] hresp_i, htrans_i;
    logic [3:0] grant_o;
    logic [1:0] addr_owner_o, data_owner_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        int    eg;
        int    eo;
        int    ed;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    ahb_prio_arbiter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req_i    (bus_req_i),
        .bus_lock_i   (bus_lock_i),
        .hready_i     (hready_i),
        .hresp_i      (hresp_i),
        .htrans_i     (htrans_i),
        .split_clr_i  (split_clr_i),
        .grant_o      (grant_o),
        .addr_owner_o (addr_owner_o),
        .data_owner_o (data_owner_o)
    );

    // Drive one cycle of inputs and queue the values expected during it.
    task automatic step(input logic [3:0] rq, input logic [3:0] lk, input logic rdy,
                        input logic [1:0] rsp, input logic [3:0] clr,
                        input int eg, input int eo, input int ed, input string tag);
        exp_t e;
        @(negedge clk);
        bus_req_i   = rq;
        bus_lock_i  = lk;
        hready_i    = rdy;
        hresp_i     = rsp;
        split_clr_i = clr;
        e.eg = eg; e.eo = eo; e.ed = ed; e.tag = tag;
        sb.push_back(e);
    endtask

    // Compare one observed field with its expected value.
    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pop the queued expectation mid-cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "grant", int'(grant_o), 1 << e.eg);
                cmp(e.tag, "addr_owner", int'(addr_owner_o), e.eo);
                cmp(e.tag, "data_owner", int'(data_owner_o), e.ed);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus: resp 00 OKAY, 10 RETRY, 11 SPLIT; htrans held NONSEQ.
    initial begin
        rst_n = 1'b0; bus_req_i = '0; bus_lock_i = '0; split_clr_i = '0;
        hready_i = 1'b1; hresp_i = 2'b00; htrans_i = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0000, 4'b0000, 1, 2'b00, 4'b0000, 1, 1, 1, "R1");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 2, 1, 1, "R2");
        step(4'b0110, 4'b0000, 1, 2'b00, 4'b0000, 2, 2, 1, "R2");
        step(4'b1110, 4'b0000, 1, 2'b00, 4'b0000, 3, 2, 2, "R2");
        step(4'b1111, 4'b0000, 1, 2'b00, 4'b0000, 3, 3, 2, "R5");
        step(4'b0111, 4'b0000, 1, 2'b00, 4'b0000, 0, 3, 3, "R6");
        step(4'b1001, 4'b0000, 1, 2'b00, 4'b0000, 3, 0, 3, "R6");
        step(4'b0010, 4'b0000, 0, 2'b00, 4'b0000, 1, 3, 0, "R4");
        step(4'b0100, 4'b0000, 0, 2'b00, 4'b0000, 2, 3, 0, "R4");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 2, 3, 0, "R4");
        step(4'b0100, 4'b0100, 1, 2'b00, 4'b0000, 2, 2, 3, "R5");
        step(4'b1100, 4'b0100, 1, 2'b00, 4'b0000, 2, 2, 2, "R7");
        step(4'b1100, 4'b0100, 0, 2'b10, 4'b0000, 2, 2, 2, "R7");
        step(4'b1100, 4'b0100, 1, 2'b10, 4'b0000, 3, 2, 2, "R11");
        step(4'b1000, 4'b0000, 1, 2'b00, 4'b0000, 3, 3, 2, "R2");
        step(4'b0100, 4'b0100, 1, 2'b00, 4'b0000, 2, 3, 3, "R2");
        step(4'b0100, 4'b0100, 1, 2'b00, 4'b0000, 2, 2, 3, "R7");
        step(4'b0100, 4'b0100, 0, 2'b11, 4'b0000, 2, 2, 2, "R7");
        step(4'b0110, 4'b0100, 1, 2'b11, 4'b0000, 0, 2, 2, "R9");
        step(4'b0110, 4'b0000, 1, 2'b00, 4'b0000, 1, 0, 2, "R8");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 1, 1, 0, "R8");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0100, 1, 1, 1, "R8");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 2, 1, 1, "R8");
        step(4'b0000, 4'b0000, 1, 2'b00, 4'b0000, 1, 2, 1, "R2");
        step(4'b0000, 4'b0000, 1, 2'b00, 4'b0000, 1, 1, 2, "R2");
        step(4'b0000, 4'b0000, 1, 2'b11, 4'b0000, 0, 1, 1, "R10");
        step(4'b0000, 4'b0000, 1, 2'b00, 4'b0000, 0, 0, 1, "R10");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 2, 0, 0, "R10");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 2, 2, 0, "R2");
        step(4'b0100, 4'b0000, 1, 2'b11, 4'b0010, 0, 2, 2, "R8");
        step(4'b0100, 4'b0000, 1, 2'b00, 4'b0000, 1, 0, 2, "R8");
        step(4'b1000, 4'b0000, 1, 2'b00, 4'b0000, 3, 1, 0, "R2");
        step(4'b1000, 4'b0000, 1, 2'b11, 4'b0000, 3, 3, 1, "R8");
        step(4'b1110, 4'b0000, 1, 2'b11, 4'b0000, 0, 3, 3, "R10");
        step(4'b1110, 4'b0000, 1, 2'b00, 4'b0000, 0, 0, 3, "R10");
        step(4'b1110, 4'b0000, 1, 2'b00, 4'b1110, 0, 0, 0, "R8");
        step(4'b1110, 4'b0000, 1, 2'b00, 4'b0000, 3, 0, 0, "R3");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule